// File: doc/BRIEF.md
# Interrupt Vectoring Unit

This block is the interrupt controller that sits beside the fetch and execute logic of a small 8-bit core. It keeps a flag and an enable for each interrupt source. The sources are one synchronous core-side source, one external pin, and a group of peripheral sources that share a group enable. A master enable gates every source. The block also keeps a small return-address stack. It watches a four-phase instruction cycle (phases Q1..Q4, one clock each) that it generates itself. At each Q1 it decides whether to divert the core. When it diverts the core, it clears the master enable, pushes the core's current PC, drives a one-clock PC load with the fixed vector 0x0004, and asserts a flush for one whole instruction cycle, which is the dummy cycle.

Software reaches the enables and flags through a small register port. A return request pops the saved PC back into the core and sets the master enable again in the same clock. Flags are never cleared by the hardware. If an interrupt service routine leaves a flag set while its enable is set, the same interrupt is taken again right after the return. The external pin is synchronised, edge-detected on a selectable polarity, and may only reach its flag in phases Q4 and Q1.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the following are all zero: the master enable, the group enable, every enable, every flag and the stack pointer. The phase counter is at Q1 (q_phase = 0), and pc_load and flush are low.
- R2: A source flag is set on the clock edge where its event input is high, whatever any enable holds. If a software write to that flag happens on the same edge, the event wins.
- R3: The controller samples the flags only in phase Q1. It diverts the core only when the master enable is set and one of these holds: the core flag and its enable are both set; the pin flag and its enable are both set; or the group enable is set and some peripheral flag is set together with its own enable.
- R4: On a diversion, the block acts on the clock edge that ends Q1. It clears the master enable and pushes cur_pc. In the next clock, pc_load is high for exactly one clock with pc_next = 0x0004. flush is high for the four clocks that form the dummy instruction cycle.
- R5: While the master enable is clear, events still set their flags, but no diversion occurs. When software sets the master enable, a pending enabled flag is taken at the next Q1.
- R6: A ret_req pulse, on one edge, pops the stack top into pc_next with a one-clock pc_load and sets the master enable. A ret_req in a Q1 clock suppresses a diversion in that same clock.
- R7: Entry leaves every flag unchanged. If a flag is still set with its enable set when the routine returns, the block diverts again at the next Q1 after the return.
- R8: ext_pin passes through two synchroniser flops and then an edge detector. ext_rise_sel = 1 selects rising edges and 0 selects falling edges. A detected edge sets the pin flag only in a Q4 or Q1 clock. An edge detected in Q2 or Q3 is held until the next Q4.
- R9: The return stack is a LIFO with 8 entries. A ninth push wraps and overwrites the oldest entry, and no error is signalled.
- R10: The register map has four addresses. Address 0 is control: bit 7 master enable, bit 6 group enable, bit 5 core enable, bit 4 pin enable, bit 2 core flag, bit 1 pin flag, and the other bits read 0. Address 1 holds the peripheral enables and address 2 the peripheral flags, with bit i for source i. Address 3 reads 0. reg_rdata is a combinational function of reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one clock per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| q_phase | output | 2 | Current phase, 0 = Q1 .. 3 = Q4 |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_rise_sel | input | 1 | 1: rising edge, 0: falling edge |
| core_evt | input | 1 | Synchronous core-source event pulse |
| per_evt | input | NPER | Peripheral event pulses |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cur_pc | input | PCW | Core PC, pushed on entry |
| ret_req | input | 1 | Return-from-interrupt pulse |
| pc_load | output | 1 | One-clock PC load strobe |
| pc_next | output | PCW | Address to load into the PC |
| flush | output | 1 | Discard prefetch / dummy cycle |

## Verification
The bench aims at the following corner cases.
- Events that arrive while the master enable is clear. A design that gated flags on the enables would lose them.
- A routine that returns without clearing its flag. A design that cleared flags on entry would not take the interrupt again.
- A pending peripheral flag while the group enable is off. A design that ignored the group enable would enter the routine.
- Pin edges in every phase and of both polarities. A wrong phase gate or a wrong polarity select changes the cycle in which the pin flag appears, or stops it appearing at all.
- Nine nested entries followed by nine returns. A design that stopped at a full stack, or wrapped it wrongly, would hand back a wrong return address on the deepest pops.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PEN  = 2'd1;
  localparam logic [1:0] ADDR_PFLG = 2'd2;

  localparam int CB_GIE    = 7;
  localparam int CB_PEIE   = 6;
  localparam int CB_CEN    = 5;
  localparam int CB_XEN    = 4;
  localparam int CB_CFLG   = 2;
  localparam int CB_XFLG   = 1;

  localparam int PHASES = 4;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  input  logic gate_open,
  output logic set_flag
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   hold_q;
  logic                   hold_d;
  logic                   edge_hit;
  logic                   synced;

  assign synced   = sync_q[SYNC_STAGES-1];
  assign edge_hit = rise_sel ? (synced & ~prev_q) : (~synced & prev_q);

  always_comb begin
    set_flag = (edge_hit | hold_q) & gate_open;
    hold_d   = (edge_hit | hold_q) & ~gate_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= synced;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] sp_q, sp_d;
  logic [PW-1:0] sp_inc, sp_dec;

  always_comb begin
    sp_inc = (sp_q == LAST) ? '0 : sp_q + 1'b1;
    sp_dec = (sp_q == '0) ? LAST : sp_q - 1'b1;
    sp_d   = sp_q;
    if (push)     sp_d = sp_inc;
    else if (pop) sp_d = sp_dec;
  end

  assign top_data = mem_q[sp_dec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      sp_q <= sp_d;
      if (push) mem_q[sp_q] <= push_data;
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int NPER   = 8,
  parameter int PCW    = 13,
  parameter int DEPTH  = 8,
  parameter int VECTOR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [1:0]      q_phase,
  input  logic            ext_pin,
  input  logic            ext_rise_sel,
  input  logic            core_evt,
  input  logic [NPER-1:0] per_evt,
  input  logic            reg_wr_en,
  input  logic [1:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [PCW-1:0]  cur_pc,
  input  logic            ret_req,
  output logic            pc_load,
  output logic [PCW-1:0]  pc_next,
  output logic            flush
);
  localparam logic [PCW-1:0] VEC_ADDR = PCW'(VECTOR);
  localparam int FCW = $clog2(PHASES + 1);
  localparam logic [FCW-1:0] FLUSH_LEN = FCW'(PHASES);

  phase_e         phase_q, phase_d;
  logic           gie_q, gie_d, peie_q, peie_d;
  logic           cen_q, cen_d, xen_q, xen_d;
  logic           cflg_q, cflg_d, xflg_q, xflg_d;
  logic [NPER-1:0] pen_q, pen_d, pflg_q, pflg_d;
  logic           load_q, load_d;
  logic [PCW-1:0] pcn_q, pcn_d;
  logic [FCW-1:0] fcnt_q, fcnt_d;

  logic           ext_set, gate_open, pending, take;
  logic           wr_ctrl, wr_pen, wr_pflg;
  logic [PCW-1:0] stack_top;

  assign gate_open = (phase_q == PH_Q4) || (phase_q == PH_Q1);

  irq_pin_sync #(.SYNC_STAGES(2)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise_sel(ext_rise_sel),
    .gate_open(gate_open), .set_flag(ext_set)
  );

  irq_ret_stack #(.DEPTH(DEPTH), .W(PCW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(take), .pop(ret_req),
    .push_data(cur_pc), .top_data(stack_top)
  );

  assign wr_ctrl = reg_wr_en && (reg_addr == ADDR_CTRL);
  assign wr_pen  = reg_wr_en && (reg_addr == ADDR_PEN);
  assign wr_pflg = reg_wr_en && (reg_addr == ADDR_PFLG);

  assign pending = (cflg_q & cen_q) | (xflg_q & xen_q) | (peie_q & |(pflg_q & pen_q));
  assign take    = (phase_q == PH_Q1) & gie_q & pending & ~ret_req;

  // next-state logic
  always_comb begin
    phase_d = phase_e'(phase_q + 2'd1);
    peie_d  = wr_ctrl ? reg_wdata[CB_PEIE] : peie_q;
    cen_d   = wr_ctrl ? reg_wdata[CB_CEN]  : cen_q;
    xen_d   = wr_ctrl ? reg_wdata[CB_XEN]  : xen_q;
    cflg_d  = (wr_ctrl ? reg_wdata[CB_CFLG] : cflg_q) | core_evt;
    xflg_d  = (wr_ctrl ? reg_wdata[CB_XFLG] : xflg_q) | ext_set;
    pen_d   = wr_pen  ? reg_wdata[NPER-1:0] : pen_q;
    pflg_d  = (wr_pflg ? reg_wdata[NPER-1:0] : pflg_q) | per_evt;

    gie_d = gie_q;
    if (ret_req)      gie_d = 1'b1;
    else if (take)    gie_d = 1'b0;
    else if (wr_ctrl) gie_d = reg_wdata[CB_GIE];

    load_d = ret_req | take;
    pcn_d  = pcn_q;
    if (ret_req)   pcn_d = stack_top;
    else if (take) pcn_d = VEC_ADDR;

    if (take)             fcnt_d = FLUSH_LEN;
    else if (fcnt_q != 0) fcnt_d = fcnt_q - 1'b1;
    else                  fcnt_d = fcnt_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_Q1;
      gie_q   <= 1'b0;
      peie_q  <= 1'b0;
      cen_q   <= 1'b0;
      xen_q   <= 1'b0;
      cflg_q  <= 1'b0;
      xflg_q  <= 1'b0;
      pen_q   <= '0;
      pflg_q  <= '0;
      load_q  <= 1'b0;
      pcn_q   <= '0;
      fcnt_q  <= '0;
    end else begin
      phase_q <= phase_d;
      gie_q   <= gie_d;
      peie_q  <= peie_d;
      cen_q   <= cen_d;
      xen_q   <= xen_d;
      cflg_q  <= cflg_d;
      xflg_q  <= xflg_d;
      pen_q   <= pen_d;
      pflg_q  <= pflg_d;
      load_q  <= load_d;
      pcn_q   <= pcn_d;
      fcnt_q  <= fcnt_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CB_GIE]  = gie_q;
        reg_rdata[CB_PEIE] = peie_q;
        reg_rdata[CB_CEN]  = cen_q;
        reg_rdata[CB_XEN]  = xen_q;
        reg_rdata[CB_CFLG] = cflg_q;
        reg_rdata[CB_XFLG] = xflg_q;
      end
      ADDR_PEN:  reg_rdata[NPER-1:0] = pen_q;
      ADDR_PFLG: reg_rdata[NPER-1:0] = pflg_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign q_phase = phase_q;
  assign pc_load = load_q;
  assign pc_next = pcn_q;
  assign flush   = (fcnt_q != '0);
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
  import irq_pkg::*;
#(
  parameter int PCW    = 13,
  parameter int VECTOR = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     q_phase,
  input logic           pc_load,
  input logic [PCW-1:0] pc_next,
  input logic           flush,
  input logic           ret_req,
  input logic           gie,
  input logic           xflg,
  input logic           reg_wr_en,
  input logic [1:0]     reg_addr
);
  localparam logic [PCW-1:0] VEC_ADDR = PCW'(VECTOR);

  AST_ENTRY_LOADS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> (pc_load && pc_next == VEC_ADDR)); // R4
  AST_ENTRY_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> !gie); // R4
  AST_ENTRY_AT_Q1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> ($past(q_phase) == PH_Q1)); // R3
  AST_ENTRY_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> $past(gie)); // R5
  AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    ret_req |=> (gie && pc_load)); // R6
  AST_PIN_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xflg) && !$past(reg_wr_en && reg_addr == ADDR_CTRL))
      |-> ($past(q_phase) == PH_Q4 || $past(q_phase) == PH_Q1)); // R8
endmodule

bind irq_vector_unit irq_vector_unit_chk #(.PCW(PCW), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .pc_load(pc_load),
  .pc_next(pc_next), .flush(flush), .ret_req(ret_req), .gie(gie_q),
  .xflg(xflg_q), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr)
);

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;
  localparam int NPER = 8;
  localparam int PCW  = 13;
  localparam int DEP  = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      q_phase;
  logic            ext_pin, ext_rise_sel, core_evt, reg_wr_en, ret_req;
  logic [NPER-1:0] per_evt;
  logic [1:0]      reg_addr;
  logic [7:0]      reg_wdata, reg_rdata;
  logic [PCW-1:0]  cur_pc, pc_next;
  logic            pc_load, flush;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_vector_unit dut_i (
    .clk(clk), .rst_n(rst_n), .q_phase(q_phase), .ext_pin(ext_pin),
    .ext_rise_sel(ext_rise_sel), .core_evt(core_evt), .per_evt(per_evt),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cur_pc(cur_pc), .ret_req(ret_req),
    .pc_load(pc_load), .pc_next(pc_next), .flush(flush)
  );

  // ---------------- reference model ----------------
  logic [1:0]      m_ph;
  logic            m_gie, m_peie, m_cen, m_xen, m_cf, m_xf;
  logic [NPER-1:0] m_pen, m_pf;
  logic            m_s1, m_s2, m_s3, m_hold;
  logic [PCW-1:0]  m_stk [DEP];
  int              m_sp;
  logic            m_load;
  logic [PCW-1:0]  m_pcn;
  int              m_fc;

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {m_gie, m_peie, m_cen, m_xen, 1'b0, m_cf, m_xf, 1'b0};
      2'd1: return m_pen;
      2'd2: return m_pf;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    m_ph = 0; m_gie = 0; m_peie = 0; m_cen = 0; m_xen = 0; m_cf = 0; m_xf = 0;
    m_pen = 0; m_pf = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_hold = 0;
    for (int i = 0; i < DEP; i++) m_stk[i] = '0;
    m_sp = 0; m_load = 0; m_pcn = '0; m_fc = 0;
  endtask

  task automatic m_step();
    logic edg, gate, xset, pend, take, wc;
    edg  = ext_rise_sel ? (m_s2 & ~m_s3) : (~m_s2 & m_s3);
    gate = (m_ph == 2'd3) || (m_ph == 2'd0);
    xset = (edg | m_hold) & gate;
    pend = (m_cf & m_cen) | (m_xf & m_xen) | (m_peie & |(m_pf & m_pen));
    take = (m_ph == 2'd0) && m_gie && pend && !ret_req;
    wc   = reg_wr_en && reg_addr == 2'd0;
    m_hold = (edg | m_hold) & ~gate;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    m_load = ret_req | take;
    if (ret_req) begin
      m_sp  = (m_sp + DEP - 1) % DEP;
      m_pcn = m_stk[m_sp];
      m_gie = 1'b1;
    end else if (take) begin
      m_stk[m_sp] = cur_pc;
      m_sp  = (m_sp + 1) % DEP;
      m_pcn = PCW'(4);
      m_gie = 1'b0;
    end else if (wc) m_gie = reg_wdata[7];
    if (take) m_fc = 4; else if (m_fc != 0) m_fc--;
    if (wc) begin
      m_peie = reg_wdata[6]; m_cen = reg_wdata[5]; m_xen = reg_wdata[4];
    end
    m_cf = (wc ? reg_wdata[2] : m_cf) | core_evt;
    m_xf = (wc ? reg_wdata[1] : m_xf) | xset;
    if (reg_wr_en && reg_addr == 2'd1) m_pen = reg_wdata;
    m_pf = ((reg_wr_en && reg_addr == 2'd2) ? reg_wdata : m_pf) | per_evt;
    m_ph = m_ph + 2'd1;
  endtask

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    m_step();
    chk("R1 phase", 32'(q_phase), 32'(m_ph));
    chk("R4 pc_load", 32'(pc_load), 32'(m_load));
    if (m_load) chk("R4,R6,R9 pc_next", 32'(pc_next), 32'(m_pcn));
    chk("R4 flush", 32'(flush), 32'(m_fc != 0));
    chk("R10 rdata", 32'(reg_rdata), 32'(m_read(reg_addr)));
  endtask

  task automatic idle();
    core_evt = 0; per_evt = 0; reg_wr_en = 0; ret_req = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    tick();
    d = reg_rdata;
  endtask

  task automatic align_q1();
    while (q_phase != 2'd0) tick();
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] d;
    int seen;
    rst_n = 0; ext_pin = 0; ext_rise_sel = 1; cur_pc = '0; reg_addr = 0; reg_wdata = 0;
    idle();
    m_reset();
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 flush", 32'(flush), 0);
    chk("R1 pc_load", 32'(pc_load), 0);
    chk("R1 phase", 32'(q_phase), 0);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reg", 32'(d), 0);
    end

    // R2: flags set with every enable off
    per_evt = 8'h21; core_evt = 1; tick(); idle();
    rd(2'd2, d); chk("R2 pflag", 32'(d), 32'h21);
    rd(2'd0, d); chk("R2 cflag", 32'(d), 32'h04);
    // R2: event beats same-cycle software clear
    reg_wr_en = 1; reg_addr = 2'd2; reg_wdata = 8'h00; per_evt = 8'h01; tick(); idle();
    rd(2'd2, d); chk("R2 set wins", 32'(d), 32'h01);

    // R3: peripheral pending but group enable off -> no entry
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h80);
    seen = 0;
    repeat (12) begin tick(); if (pc_load) seen++; end
    chk("R3 no entry without group enable", 32'(seen), 0);

    // R4: enable core source only, clear flags, fire core event
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hA0);
    cur_pc = 13'h123;
    align_q1();
    core_evt = 1; tick(); core_evt = 0;
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      tick();
      if (pc_load && pc_next == 13'h004 && seen == 0) seen = i + 1;
    end
    // event at Q1 edge -> flag, next Q1 sample is 4 clocks on, load 1 clock later
    chk("R4 vector load latency", 32'(seen), 32'd4);
    rd(2'd0, d); chk("R4 gie cleared, flag kept (R7)", 32'(d), 32'h24);

    // R5: events while disabled only set flags
    cur_pc = 13'h0AA;
    wr(2'd1, 8'h80);
    per_evt = 8'h80; tick(); idle();
    seen = 0;
    repeat (10) begin tick(); if (pc_load) seen++; end
    chk("R5 no entry while gie clear", 32'(seen), 0);
    rd(2'd2, d); chk("R5 flag captured", 32'(d), 32'h80);

    // R6: return restores PC and gie; core flag still set -> R7 re-entry
    wr(2'd0, 8'h24);
    ret_req = 1; tick(); ret_req = 0;
    chk("R6 pop pc", 32'(pc_next), 32'h123);
    chk("R6 load", 32'(pc_load), 1);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      rd(2'd0, d);
      if (pc_load && pc_next == 13'h004) seen = 1;
    end
    chk("R7 taken again after return", 32'(seen), 1);

    // R5: pending enabled flag taken once gie set again
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h40);
    wr(2'd2, 8'h80);
    seen = 0;
    repeat (8) begin tick(); if (pc_load) seen++; end
    chk("R5 held while disabled", 32'(seen), 0);
    wr(2'd0, 8'hC0);
    seen = 0;
    repeat (8) begin tick(); if (pc_load && pc_next == 13'h004) seen++; end
    chk("R5 taken after gie set", 32'(seen), 1);

    // R8: pin edges in each phase, both polarities, enable off
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    for (int p = 0; p < 4; p++) begin
      for (int pol = 0; pol < 2; pol++) begin
        ext_rise_sel = pol[0];
        ext_pin = ~pol[0];
        repeat (6) tick();
        wr(2'd0, 8'h00);
        while (q_phase != 2'(p)) tick();
        ext_pin = pol[0];
        repeat (9) tick();
        rd(2'd0, d);
        chk("R8 pin flag", 32'(d[1]), 1);
      end
    end
    ext_rise_sel = 1; ext_pin = 1;
    repeat (6) tick();
    wr(2'd0, 8'h00);
    ext_pin = 0; repeat (8) tick();
    rd(2'd0, d); chk("R8 wrong polarity ignored", 32'(d[1]), 0);

    // R9: nine nested entries then nine returns
    wr(2'd0, 8'hA4);
    for (int k = 0; k < 9; k++) begin
      cur_pc = 13'h100 + 13'(k);
      while (!pc_load) tick();
      tick();
      wr(2'd0, 8'hA4);
    end
    wr(2'd0, 8'h00);
    for (int k = 0; k < 9; k++) begin
      ret_req = 1; tick(); ret_req = 0;
      chk("R9 return order", 32'(pc_next), (k < 8) ? 32'h108 - 32'(k) : 32'h108);
      wr(2'd0, 8'h00);
    end

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      core_evt  = ($urandom % 24) == 0;
      for (int b = 0; b < NPER; b++) per_evt[b] = ($urandom % 40) == 0;
      if ($urandom % 7 == 0) ext_pin = ~ext_pin;
      if ($urandom % 200 == 0) ext_rise_sel = ~ext_rise_sel;
      reg_wr_en = ($urandom % 6) == 0;
      reg_addr  = 2'($urandom);
      reg_wdata = 8'($urandom);
      ret_req   = ($urandom % 30) == 0;
      cur_pc    = PCW'($urandom);
      tick();
    end
    idle();
    tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule